// File: doc/BRIEF.md
# Quad-Channel Serial Converter Write Controller

This block is the host-side master for a four-channel, 12-bit voltage-output converter that takes its data over a three-wire serial link and has a separate load strobe. A single command port with a valid/ready handshake accepts either a channel write (a 2-bit channel number and a 12-bit code) or a reset command carrying the level to place on the converter's reset-select line.

For a write, the controller builds a 16-bit word and shifts it out most significant bit first while chip select is low. After the last bit it raises chip select and then drives one timed low pulse on the load line, which updates the addressed channel. For a reset command, it first sets the reset-select level and then pulses the reset line low. Every pin interval comes from a nanosecond parameter rounded up to whole system clock cycles of the configured clock period, with a minimum of one cycle.

Top module: `quad_dac_host`

## Requirements
- R1: After reset, and whenever `cmdReady` is high, `dacCsN`, `dacSclk`, `dacLdacN` and `dacRstN` are all high. `cmdReady` is high only while the controller is idle. `dacRstSel` comes out of reset low.
- R2: A write sends exactly 16 serial clock rising edges while `dacCsN` is low. The bits sampled on those edges, in order, form the word {channel[1:0], 2'b00, code[11:0]}. The serial clock toggles only while chip select is low.
- R3: `dacSdi` is stable for at least ceil(25 ns/period) cycles before each serial clock rise, and for at least ceil(20 ns/period) cycles after it.
- R4: Every serial clock high phase lasts at least ceil(30 ns/period) cycles, and every low phase lasts at least ceil(50 ns/period) cycles.
- R5: Chip select is low at least ceil(55 ns/period) cycles before the first clock rise. It rises only while the serial clock is high, and at least ceil(15 ns/period) cycles after the last rise.
- R6: `dacLdacN` stays high while chip select is low, and has been high at least ceil(40 ns/period) cycles at every clock rise. Each write produces exactly one low pulse, starting after chip select has risen and at least ceil(15 ns/period) cycles after the last clock rise, and lasting at least ceil(45 ns/period) cycles.
- R7: A reset command (`cmdReset`=1) drives `dacRstSel` to `cmdMid` at least ceil(25 ns/period) cycles before `dacRstN` falls. It holds `dacRstN` low at least ceil(70 ns/period) cycles, with no chip select, clock or load activity. `dacRstSel` keeps that level afterwards.
- R8: A command is taken only on a cycle where `cmdValid` and `cmdReady` are both high, and `cmdReady` is low in the next cycle. Changes to the command inputs while busy have no effect on the frame being sent or on `dacRstSel`.
- R9: Busy time is exact. With period 8 ns, a write keeps `cmdReady` low for lead(max(55,40) ns) + 16·(low(max(50,25) ns) + high(max(30,20,15) ns)) + gap(15 ns) + pulse(45 ns) cycles, which is 7+16·(7+4)+2+6 = 191. A reset command keeps it low for 4+9 = 13 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset of the controller |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Controller idle and able to take a command |
| cmdReset | input | 1 | 1 = reset command, 0 = channel write |
| cmdChan | input | 2 | Channel number for a write |
| cmdCode | input | 12 | Converter code for a write |
| cmdMid | input | 1 | Reset-select level for a reset command |
| dacCsN | output | 1 | Converter chip select, active low |
| dacSclk | output | 1 | Serial clock, idles high |
| dacSdi | output | 1 | Serial data |
| dacLdacN | output | 1 | Load strobe, active low |
| dacRstN | output | 1 | Converter reset, active low |
| dacRstSel | output | 1 | Converter reset-select level |

## Verification
Two things can fall in the same cycle: the controller finishing a load pulse and returning to idle, and the acceptance of a command that has been waiting with `cmdValid` held high during the previous write. The bench provokes this by queueing a second write straight behind a first one. It then judges the second frame independently: the frame is reassembled bit by bit from the pins, and the load line's high time before the first clock rise, the chip-select lead and every other minimum interval are measured again for that frame. Alongside this, it sweeps all four channels across edge and pattern codes, and it changes the command inputs while the controller is busy.

// File: rtl/qdh_pkg.sv
package qdh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH,
    ST_LDGAP, ST_LDPULSE, ST_RSETUP, ST_RPULSE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic latchSel;
  } dpStrobe_t;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qdh_datapath.sv
module qdh_datapath
  import qdh_pkg::*;
#(
  parameter int CHAN_W  = 2,
  parameter int CODE_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              cmdMid,
  output logic              sdi,
  output logic              lastBit,
  output logic              rstSel
);

  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameWord;
  logic [CNT_W-1:0]   bitCnt;

  // channel in the top bits, zero padding, code in the low bits
  assign frameWord = (FRAME_W'(cmdChan) << (FRAME_W - CHAN_W)) | FRAME_W'(cmdCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      rstSel   <= 1'b0;
    end else begin
      if (strobe.loadFrame) begin
        shiftReg <= frameWord;
        bitCnt   <= '0;
      end else if (strobe.shiftBit) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (strobe.latchSel) rstSel <= cmdMid;
    end
  end

  assign sdi     = shiftReg[FRAME_W-1];
  assign lastBit = (bitCnt == CNT_W'(FRAME_W - 1));

  // control never asks for a shift beyond the last bit of the frame
  assert_no_overshift_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftBit |-> !lastBit);

endmodule

// File: rtl/qdh_ctrl.sv
module qdh_ctrl
  import qdh_pkg::*;
#(
  parameter int N_LEAD  = 7,
  parameter int N_LOW   = 7,
  parameter int N_HIGH  = 4,
  parameter int N_LDGAP = 2,
  parameter int N_LDW   = 6,
  parameter int N_RSSH  = 4,
  parameter int N_RSTW  = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdReset,
  input  logic      lastBit,
  output logic      cmdReady,
  output dpStrobe_t strobe,
  output logic      csN,
  output logic      sclk,
  output logic      ldacN,
  output logic      dacRstN
);

  localparam int LONGEST = maxOf(maxOf(maxOf(N_LEAD, N_LOW), maxOf(N_HIGH, N_LDGAP)),
                                 maxOf(maxOf(N_LDW, N_RSSH), N_RSTW));
  localparam int TW = (LONGEST < 2) ? 1 : $clog2(LONGEST + 1);

  phase_t        state, stateNext;
  logic [TW-1:0] timer, timerNext;
  logic          done;

  assign done     = (timer == '0);
  assign cmdReady = (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    timerNext = done ? timer : timer - 1'b1;
    case (state)
      ST_IDLE: if (cmdValid) begin
        if (cmdReset) begin
          stateNext       = ST_RSETUP;
          strobe.latchSel = 1'b1;
          timerNext       = TW'(N_RSSH - 1);
        end else begin
          stateNext        = ST_LEAD;
          strobe.loadFrame = 1'b1;
          timerNext        = TW'(N_LEAD - 1);
        end
      end
      ST_LEAD: if (done) begin
        stateNext = ST_LOW;
        timerNext = TW'(N_LOW - 1);
      end
      ST_LOW: if (done) begin
        stateNext = ST_HIGH;
        timerNext = TW'(N_HIGH - 1);
      end
      ST_HIGH: if (done) begin
        if (lastBit) begin
          stateNext = ST_LDGAP;
          timerNext = TW'(N_LDGAP - 1);
        end else begin
          stateNext       = ST_LOW;
          strobe.shiftBit = 1'b1;
          timerNext       = TW'(N_LOW - 1);
        end
      end
      ST_LDGAP: if (done) begin
        stateNext = ST_LDPULSE;
        timerNext = TW'(N_LDW - 1);
      end
      ST_LDPULSE: if (done) stateNext = ST_IDLE;
      ST_RSETUP: if (done) begin
        stateNext = ST_RPULSE;
        timerNext = TW'(N_RSTW - 1);
      end
      ST_RPULSE: if (done) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  // pins registered from the next phase, so they stay in step with state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
      ldacN   <= 1'b1;
      dacRstN <= 1'b1;
    end else begin
      state   <= stateNext;
      timer   <= timerNext;
      csN     <= !(stateNext == ST_LEAD || stateNext == ST_LOW || stateNext == ST_HIGH);
      sclk    <= (stateNext != ST_LOW);
      ldacN   <= (stateNext != ST_LDPULSE);
      dacRstN <= (stateNext != ST_RPULSE);
    end
  end

  assert_cs_rise_clk_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (sclk && $past(sclk)));

  assert_load_quiet_in_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> ldacN);

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (csN && sclk && ldacN && dacRstN));

  assert_reset_isolated_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dacRstN |-> (csN && sclk && ldacN));

  assert_accept_goes_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  assert_clock_inside_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> !csN);

endmodule

// File: rtl/quad_dac_host.sv
module quad_dac_host
  import qdh_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int CHAN_W        = 2,
  parameter int CODE_W        = 12,
  parameter int FRAME_W       = 16,
  parameter int T_DS_NS       = 25,
  parameter int T_DH_NS       = 20,
  parameter int T_CH_NS       = 30,
  parameter int T_CL_NS       = 50,
  parameter int T_CSS_NS      = 55,
  parameter int T_CSH_NS      = 15,
  parameter int T_LD1_NS      = 40,
  parameter int T_LD2_NS      = 15,
  parameter int T_LDW_NS      = 45,
  parameter int T_RSSH_NS     = 25,
  parameter int T_RSTW_NS     = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdReset,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              cmdMid,
  output logic              dacCsN,
  output logic              dacSclk,
  output logic              dacSdi,
  output logic              dacLdacN,
  output logic              dacRstN,
  output logic              dacRstSel
);

  localparam int N_LEAD  = maxOf(cyclesFor(T_CSS_NS, CLK_PERIOD_NS),
                                 cyclesFor(T_LD1_NS, CLK_PERIOD_NS));
  localparam int N_LOW   = cyclesFor(maxOf(T_CL_NS, T_DS_NS), CLK_PERIOD_NS);
  localparam int N_HIGH  = cyclesFor(maxOf(T_CH_NS, maxOf(T_DH_NS, T_CSH_NS)), CLK_PERIOD_NS);
  localparam int N_LDGAP = cyclesFor(T_LD2_NS, CLK_PERIOD_NS);
  localparam int N_LDW   = cyclesFor(T_LDW_NS, CLK_PERIOD_NS);
  localparam int N_RSSH  = cyclesFor(T_RSSH_NS, CLK_PERIOD_NS);
  localparam int N_RSTW  = cyclesFor(T_RSTW_NS, CLK_PERIOD_NS);

  dpStrobe_t strobe;
  logic      lastBit;

  qdh_ctrl #(
    .N_LEAD(N_LEAD), .N_LOW(N_LOW), .N_HIGH(N_HIGH), .N_LDGAP(N_LDGAP),
    .N_LDW(N_LDW), .N_RSSH(N_RSSH), .N_RSTW(N_RSTW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReset(cmdReset),
    .lastBit(lastBit), .cmdReady(cmdReady), .strobe(strobe),
    .csN(dacCsN), .sclk(dacSclk), .ldacN(dacLdacN), .dacRstN(dacRstN)
  );

  qdh_datapath #(
    .CHAN_W(CHAN_W), .CODE_W(CODE_W), .FRAME_W(FRAME_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdChan(cmdChan),
    .cmdCode(cmdCode), .cmdMid(cmdMid), .sdi(dacSdi), .lastBit(lastBit),
    .rstSel(dacRstSel)
  );

endmodule

// File: tb/quad_dac_host_tb_top.sv
module quad_dac_host_tb_top;

  localparam int P = 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction

  // minimum intervals, in cycles
  localparam int N_DS = cyc(25), N_DH = cyc(20), N_CH = cyc(30), N_CL = cyc(50);
  localparam int N_CSS = cyc(55), N_CSH = cyc(15), N_LD1 = cyc(40), N_LD2 = cyc(15);
  localparam int N_LDW = cyc(45), N_RSSH = cyc(25), N_RSTW = cyc(70);
  // exact busy lengths
  localparam int WR_BUSY = ((N_CSS > N_LD1) ? N_CSS : N_LD1) + 16 * (cyc(50) + cyc(30)) + N_LD2 + N_LDW;
  localparam int RS_BUSY = N_RSSH + N_RSTW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReset = 1'b0, cmdMid = 1'b0;
  logic [1:0]  cmdChan = '0;
  logic [11:0] cmdCode = '0;
  logic cmdReady, dacCsN, dacSclk, dacSdi, dacLdacN, dacRstN, dacRstSel;

  always #(P/2) clk = ~clk;

  quad_dac_host #(.CLK_PERIOD_NS(P)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdReset(cmdReset), .cmdChan(cmdChan), .cmdCode(cmdCode), .cmdMid(cmdMid),
    .dacCsN(dacCsN), .dacSclk(dacSclk), .dacSdi(dacSdi), .dacLdacN(dacLdacN),
    .dacRstN(dacRstN), .dacRstSel(dacRstSel)
  );

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected frames
  logic [15:0] expQ [0:63];
  int qWr = 0, qRd = 0;
  logic expSel = 1'b0;
  int writes = 0;

  // pin monitor, sampled on the falling clock edge
  logic pCs, pSclk, pSdi, pLd, pRst, pSel;
  int sdiAge, sclkAge, csAge, ldAge, rstAge, selAge;
  int sinceRise = 1000, riseCnt = 0, frames = 0, pulses = 0;
  logic [15:0] frameAcc = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      pCs = dacCsN; pSclk = dacSclk; pSdi = dacSdi; pLd = dacLdacN;
      pRst = dacRstN; pSel = dacRstSel;
      sdiAge = 1; sclkAge = 1; csAge = 1; ldAge = 1; rstAge = 1; selAge = 1;
    end else begin
      automatic int sclkRun = sclkAge, ldRun = ldAge, rstRun = rstAge;
      automatic bit sclkRose = !pSclk && dacSclk, sclkFell = pSclk && !dacSclk;
      automatic bit csFell = pCs && !dacCsN, csRose = !pCs && dacCsN;
      automatic bit ldFell = pLd && !dacLdacN, ldRose = !pLd && dacLdacN;
      automatic bit rstFell = pRst && !dacRstN, rstRose = !pRst && dacRstN;
      automatic bit sdiChg = (pSdi != dacSdi);
      sdiAge  = sdiChg ? 1 : sdiAge + 1;
      sclkAge = (sclkRose || sclkFell) ? 1 : sclkAge + 1;
      csAge   = (csFell || csRose) ? 1 : csAge + 1;
      ldAge   = (ldFell || ldRose) ? 1 : ldAge + 1;
      rstAge  = (rstFell || rstRose) ? 1 : rstAge + 1;
      selAge  = (pSel != dacRstSel) ? 1 : selAge + 1;
      sinceRise++;

      if (sdiChg && !dacCsN && riseCnt > 0)
        check(sinceRise >= N_DH, "R3", "data hold after clock rise", sinceRise, N_DH);
      if (csFell) begin
        riseCnt = 0;
        check(dacLdacN == 1'b1, "R6", "load high at frame start", dacLdacN, 1);
      end
      if (sclkRose) begin
        check(!dacCsN, "R2", "clock rise inside frame", dacCsN, 0);
        check(sdiAge - 1 >= N_DS, "R3", "data setup before rise", sdiAge - 1, N_DS);
        check(sclkRun >= N_CL, "R4", "clock low time", sclkRun, N_CL);
        check(dacLdacN && ldAge - 1 >= N_LD1, "R6", "load high before rise", ldAge - 1, N_LD1);
        if (riseCnt == 0)
          check(csAge - 1 >= N_CSS, "R5", "chip select lead", csAge - 1, N_CSS);
        frameAcc = {frameAcc[14:0], dacSdi};
        riseCnt++;
        sinceRise = 0;
      end
      if (sclkFell) begin
        check(!dacCsN, "R2", "clock fall inside frame", dacCsN, 0);
        check(sclkRun >= N_CH, "R4", "clock high time", sclkRun, N_CH);
      end
      if (csRose) begin
        check(dacSclk && pSclk, "R5", "clock high at chip select rise", dacSclk, 1);
        check(sinceRise >= N_CSH, "R5", "last rise to chip select rise", sinceRise, N_CSH);
        check(riseCnt == 16, "R2", "rising edges per frame", riseCnt, 16);
        check(qRd < qWr && frameAcc == expQ[qRd], "R2", "reassembled frame",
              frameAcc, expQ[qRd]);
        qRd++;
        frames++;
      end
      if (!dacCsN && !dacLdacN)
        check(1'b0, "R6", "load low during frame", dacLdacN, 1);
      if (!dacRstN && (!dacCsN || !dacSclk || !dacLdacN))
        check(1'b0, "R7", "serial activity during reset", {dacCsN, dacSclk, dacLdacN}, 7);
      if (ldFell) begin
        check(dacCsN, "R6", "load pulse after chip select rise", dacCsN, 1);
        check(sinceRise >= N_LD2, "R6", "last rise to load fall", sinceRise, N_LD2);
        check(frames == pulses + 1, "R6", "one pulse per frame", pulses + 1, frames);
      end
      if (ldRose) begin
        check(ldRun >= N_LDW, "R6", "load pulse width", ldRun, N_LDW);
        pulses++;
      end
      if (rstFell) begin
        check(dacRstSel == expSel, "R7", "reset-select level", dacRstSel, expSel);
        check(selAge - 1 >= N_RSSH, "R7", "reset-select setup", selAge - 1, N_RSSH);
      end
      if (rstRose)
        check(rstRun >= N_RSTW, "R7", "reset low width", rstRun, N_RSTW);

      pCs = dacCsN; pSclk = dacSclk; pSdi = dacSdi; pLd = dacLdacN;
      pRst = dacRstN; pSel = dacRstSel;
    end
  end

  task automatic waitIdle();
    while (!cmdReady) @(negedge clk);
  endtask

  task automatic doWrite(input logic [1:0] ch, input logic [11:0] code);
    int busy;
    @(negedge clk);
    waitIdle();
    cmdValid = 1'b1; cmdReset = 1'b0; cmdChan = ch; cmdCode = code;
    expQ[qWr] = {ch, 2'b00, code}; qWr++; writes++;
    @(negedge clk);
    cmdValid = 1'b0; cmdChan = ~ch; cmdCode = ~code; cmdMid = ~cmdMid; // R8 ignored while busy
    check(!cmdReady, "R8", "ready drops after accept", cmdReady, 0);
    busy = 0;
    while (!cmdReady) begin busy++; @(negedge clk); end
    check(busy == WR_BUSY, "R9", "write busy cycles", busy, WR_BUSY);
    check(dacRstSel == expSel, "R8", "reset-select untouched by write", dacRstSel, expSel);
  endtask

  task automatic doReset(input logic sel);
    int busy;
    @(negedge clk);
    waitIdle();
    cmdValid = 1'b1; cmdReset = 1'b1; cmdMid = sel; expSel = sel;
    @(negedge clk);
    cmdValid = 1'b0; cmdReset = 1'b0; cmdMid = ~sel;
    busy = 0;
    while (!cmdReady) begin busy++; @(negedge clk); end
    check(busy == RS_BUSY, "R9", "reset busy cycles", busy, RS_BUSY);
    repeat (3) @(negedge clk);
    check(dacRstSel == sel, "R7", "reset-select held afterwards", dacRstSel, sel);
    check(dacRstN && dacCsN && dacLdacN, "R1", "idle after reset command", dacRstN, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b1, "R1", "ready after reset", cmdReady, 1);
    check(dacCsN && dacSclk, "R1", "chip select and clock idle high", {dacCsN, dacSclk}, 3);
    check(dacLdacN && dacRstN, "R1", "load and reset idle high", {dacLdacN, dacRstN}, 3);
    check(dacRstSel == 1'b0, "R1", "reset-select after reset", dacRstSel, 0);

    // sweep all channels over edge and pattern codes
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 8; k++) begin
        logic [11:0] code;
        case (k)
          0: code = 12'h000;
          1: code = 12'hFFF;
          2: code = 12'h800;
          3: code = 12'h7FF;
          default: code = 12'((k * 683 + ch * 273) & 12'hFFF);
        endcase
        doWrite(2'(ch), code);
      end
    end

    doReset(1'b1);
    doReset(1'b0);
    doReset(1'b1);
    doWrite(2'd2, 12'h5A5);

    // back-to-back: second command waits and is taken as idle returns
    @(negedge clk);
    waitIdle();
    cmdValid = 1'b1; cmdReset = 1'b0; cmdChan = 2'd1; cmdCode = 12'hC3C;
    expQ[qWr] = {2'd1, 2'b00, 12'hC3C}; qWr++; writes++;
    @(negedge clk);
    cmdChan = 2'd3; cmdCode = 12'h0F1;
    expQ[qWr] = {2'd3, 2'b00, 12'h0F1}; qWr++; writes++;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    check(!cmdReady, "R8", "queued command taken at idle", cmdReady, 0);
    cmdValid = 1'b0;
    waitIdle();
    repeat (4) @(negedge clk);

    check(frames == writes, "R2", "frames sent", frames, writes);
    check(pulses == writes, "R6", "load pulses", pulses, writes);
    check(qRd == qWr, "R2", "expected frames consumed", qRd, qWr);
    check(dacRstSel == 1'b1, "R7", "reset-select kept across writes", dacRstSel, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule